// File: doc/BRIEF.md
# PLL Multiplier and VCO Range Calculator

This block turns a requested output frequency into the integer feedback multiplier a PLL needs, given the reference frequency that feeds it. The request is first limited to an allowed window, then raised to the next whole multiple of the reference. If that multiple lands above the window's upper edge, the block backs off by one reference step. Alongside the multiplier it reports the frequency that will actually result, and a range bit that steers the oscillator to its high band when that frequency is above a programmable threshold.

All frequencies are unsigned integers of one common width. A calculation starts with a one-cycle `start` pulse. A multi-cycle restoring divider then runs, and `valid` pulses for one cycle when the results are ready. The results stay on their ports until the next completion. A readback output always shows the stored multiplier times the present reference input. A zero reference cannot be divided by. It finishes at once, with an error flag and zero results.

Top module: `pll_mult_calc`

## Requirements
- R1: The request is clamped to the inclusive window [min_rate, max_rate] before rounding (min_rate <= max_rate is assumed); a request below the window behaves as min_rate and one above it as max_rate.
- R2: With a nonzero reference, rate_out is the smallest multiple of ref_rate that is at or above the clamped request, and rate_out equals mult_l times ref_rate.
- R3: When the rounded multiple exceeds max_rate, one ref_rate is subtracted, so rate_out never exceeds max_rate; this holds even when the rounded value passes the top of the rate width.
- R4: mult_l equals rate_out divided by ref_rate, truncated.
- R5: vco_hi is 0 when rate_out <= vco_thresh and 1 when rate_out > vco_thresh.
- R6: cur_rate equals the stored mult_l multiplied by the current ref_rate input, at full double width.
- R7: A start with ref_rate equal to 0 completes with valid one cycle later, ref_err = 1, and mult_l, rate_out and vco_hi all 0; ref_err is 0 after any calculation with a nonzero reference.
- R8: valid is a single-cycle pulse; busy is high from the accepted start until valid; a start pulse seen while busy is ignored and does not change the result.
- R9: After reset, valid, busy, ref_err, vco_hi, mult_l, rate_out and cur_rate are all 0.
- R10: rate_out, mult_l, vco_hi and ref_err hold their values after valid until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a calculation |
| req_rate | input | W | Requested output rate |
| ref_rate | input | W | Reference rate |
| min_rate | input | W | Lowest allowed rate |
| max_rate | input | W | Highest allowed rate |
| vco_thresh | input | W | Highest rate served by the low oscillator band |
| busy | output | 1 | Calculation in progress |
| valid | output | 1 | One-cycle completion pulse |
| rate_out | output | W | Rate that the chosen multiplier produces |
| mult_l | output | W | Integer feedback multiplier |
| vco_hi | output | 1 | High oscillator band selected |
| ref_err | output | 1 | Last calculation saw a zero reference |
| cur_rate | output | 2*W | Stored multiplier times ref_rate |

## Verification
The bench builds the block with W = 16. At that width the random limits and references easily reach the top of the rate range. Rounding up then carries past 16 bits, and the step-down of R3 must recover from that carry. References larger than the whole window are also common, so a multiplier of zero appears regularly. The short divider leaves room for many random calculations, plus directed cases for the clamp edges, exact multiples, a threshold equal to the result, a zero reference, and a start issued while busy.

// File: rtl/pll_calc_pkg.sv
package pll_calc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_KICK = 2'd1,
        ST_WAIT = 2'd2
    } calc_state_e;
endpackage

// File: rtl/pll_rate_clamp.sv
module pll_rate_clamp #(
    parameter int W = 32
) (
    input  logic [W-1:0] req_rate,
    input  logic [W-1:0] lo_rate,
    input  logic [W-1:0] hi_rate,
    output logic [W-1:0] clamped
);
    always_comb begin
        if (req_rate < lo_rate) begin
            clamped = lo_rate;
        end else if (req_rate > hi_rate) begin
            clamped = hi_rate;
        end else begin
            clamped = req_rate;
        end
    end
endmodule

// File: rtl/pll_restoring_div.sv
module pll_restoring_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder
);
    localparam int CNT_W = (W > 1) ? $clog2(W) : 1;

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     rem;
        logic [W-1:0]     quo;
        logic             done;
    } div_state_t;

    div_state_t st_d, st_q;
    logic [W:0] shifted;
    logic       fits;

    always_comb begin
        st_d     = st_q;
        st_d.done = 1'b0;
        shifted  = {st_q.rem, st_q.quo[W-1]};
        fits     = (shifted >= {1'b0, divisor});
        if (!st_q.run) begin
            if (start) begin
                st_d.run = 1'b1;
                st_d.cnt = CNT_W'(W - 1);
                st_d.rem = '0;
                st_d.quo = dividend;
            end
        end else begin
            if (fits) begin
                st_d.rem = W'(shifted - {1'b0, divisor});
                st_d.quo = {st_q.quo[W-2:0], 1'b1};
            end else begin
                st_d.rem = W'(shifted);
                st_d.quo = {st_q.quo[W-2:0], 1'b0};
            end
            if (st_q.cnt == '0) begin
                st_d.run  = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done      = st_q.done;
    assign quotient  = st_q.quo;
    assign remainder = st_q.rem;
endmodule

// File: rtl/pll_round_pick.sv
module pll_round_pick #(
    parameter int W = 32
) (
    input  logic [W-1:0] quo,
    input  logic [W-1:0] rem,
    input  logic [W-1:0] divisor,
    input  logic [W-1:0] hi_rate,
    input  logic [W-1:0] thresh,
    output logic [W-1:0] rate,
    output logic [W-1:0] mult,
    output logic         band_hi
);
    localparam int PW = 2 * W + 1;

    logic [W:0]    q_up;
    logic [PW-1:0] prod;
    logic          over;

    always_comb begin
        q_up = {1'b0, quo} + ((rem != '0) ? (W+1)'(1) : (W+1)'(0));
        prod = PW'(q_up) * PW'(divisor);
        over = (prod > PW'(hi_rate));
        if (over) begin
            mult = W'(q_up - (W+1)'(1));
            rate = W'(prod - PW'(divisor));
        end else begin
            mult = W'(q_up);
            rate = W'(prod);
        end
        band_hi = (rate > thresh);
    end
endmodule

// File: rtl/pll_mult_calc.sv
module pll_mult_calc
    import pll_calc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [W-1:0]   req_rate,
    input  logic [W-1:0]   ref_rate,
    input  logic [W-1:0]   min_rate,
    input  logic [W-1:0]   max_rate,
    input  logic [W-1:0]   vco_thresh,
    output logic           busy,
    output logic           valid,
    output logic [W-1:0]   rate_out,
    output logic [W-1:0]   mult_l,
    output logic           vco_hi,
    output logic           ref_err,
    output logic [2*W-1:0] cur_rate
);
    localparam int RW = 2 * W;

    typedef struct packed {
        calc_state_e  state;
        logic [W-1:0] clamp;
        logic [W-1:0] refr;
        logic [W-1:0] hi;
        logic [W-1:0] thr;
        logic [W-1:0] rate;
        logic [W-1:0] mult;
        logic         band;
        logic         err;
        logic         valid;
    } calc_t;

    calc_t c_d, c_q;

    logic [W-1:0] clamped_in;
    logic         div_start;
    logic         div_done;
    logic [W-1:0] div_quo;
    logic [W-1:0] div_rem;
    logic [W-1:0] pick_rate;
    logic [W-1:0] pick_mult;
    logic         pick_band;

    pll_rate_clamp #(.W(W)) clamp_i (
        .req_rate (req_rate),
        .lo_rate  (min_rate),
        .hi_rate  (max_rate),
        .clamped  (clamped_in)
    );

    pll_restoring_div #(.W(W)) div_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (div_start),
        .dividend  (c_q.clamp),
        .divisor   (c_q.refr),
        .done      (div_done),
        .quotient  (div_quo),
        .remainder (div_rem)
    );

    pll_round_pick #(.W(W)) pick_i (
        .quo     (div_quo),
        .rem     (div_rem),
        .divisor (c_q.refr),
        .hi_rate (c_q.hi),
        .thresh  (c_q.thr),
        .rate    (pick_rate),
        .mult    (pick_mult),
        .band_hi (pick_band)
    );

    always_comb begin
        c_d       = c_q;
        c_d.valid = 1'b0;
        div_start = 1'b0;
        case (c_q.state)
            ST_IDLE: begin
                if (start) begin
                    if (ref_rate == '0) begin
                        c_d.rate  = '0;
                        c_d.mult  = '0;
                        c_d.band  = 1'b0;
                        c_d.err   = 1'b1;
                        c_d.valid = 1'b1;
                    end else begin
                        c_d.clamp = clamped_in;
                        c_d.refr  = ref_rate;
                        c_d.hi    = max_rate;
                        c_d.thr   = vco_thresh;
                        c_d.state = ST_KICK;
                    end
                end
            end
            ST_KICK: begin
                div_start = 1'b1;
                c_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (div_done) begin
                    c_d.rate  = pick_rate;
                    c_d.mult  = pick_mult;
                    c_d.band  = pick_band;
                    c_d.err   = 1'b0;
                    c_d.valid = 1'b1;
                    c_d.state = ST_IDLE;
                end
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign busy     = (c_q.state != ST_IDLE);
    assign valid    = c_q.valid;
    assign rate_out = c_q.rate;
    assign mult_l   = c_q.mult;
    assign vco_hi   = c_q.band;
    assign ref_err  = c_q.err;
    assign cur_rate = RW'(c_q.mult) * RW'(ref_rate);
endmodule

// File: rtl/pll_mult_calc_chk.sv
module pll_mult_calc_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [W-1:0] ref_rate,
    input logic [W-1:0] max_rate,
    input logic [W-1:0] vco_thresh,
    input logic         busy,
    input logic         valid,
    input logic [W-1:0] rate_out,
    input logic [W-1:0] mult_l,
    input logic         vco_hi,
    input logic         ref_err
);
    localparam int PW = 2 * W;

    logic [W-1:0] ref_cap_q, max_cap_q, thr_cap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_cap_q <= '0;
            max_cap_q <= '0;
            thr_cap_q <= '0;
        end else if (start && !busy) begin
            ref_cap_q <= ref_rate;
            max_cap_q <= max_rate;
            thr_cap_q <= vco_thresh;
        end
    end

    // R8
    a_r8_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);
    // R8
    a_r8_idle_at_valid: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> !busy);
    // R3
    a_r3_not_above_max: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ref_err) |-> (rate_out <= max_cap_q));
    // R2
    a_r2_rate_is_multiple: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ref_err) |-> (PW'(rate_out) == PW'(mult_l) * PW'(ref_cap_q)));
    // R5
    a_r5_band_choice: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ref_err) |-> (vco_hi == (rate_out > thr_cap_q)));
    // R7
    a_r7_zero_ref_results: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ref_err) |-> (mult_l == '0 && rate_out == '0 && !vco_hi));
endmodule

bind pll_mult_calc pll_mult_calc_chk #(.W(W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .ref_rate   (ref_rate),
    .max_rate   (max_rate),
    .vco_thresh (vco_thresh),
    .busy       (busy),
    .valid      (valid),
    .rate_out   (rate_out),
    .mult_l     (mult_l),
    .vco_hi     (vco_hi),
    .ref_err    (ref_err)
);

// File: tb/pll_mult_calc_tb_top.sv
module pll_mult_calc_tb_top;
    localparam int W = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [W-1:0]   req_rate = '0, ref_rate = '0, min_rate = '0, max_rate = '0, vco_thresh = '0;
    logic           busy, valid, vco_hi, ref_err;
    logic [W-1:0]   rate_out, mult_l;
    logic [2*W-1:0] cur_rate;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    pll_mult_calc #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .req_rate(req_rate),
        .ref_rate(ref_rate), .min_rate(min_rate), .max_rate(max_rate),
        .vco_thresh(vco_thresh), .busy(busy), .valid(valid),
        .rate_out(rate_out), .mult_l(mult_l), .vco_hi(vco_hi),
        .ref_err(ref_err), .cur_rate(cur_rate)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint exp_rate(input longint req, input longint rf,
                                        input longint mn, input longint mx);
        longint c, r;
        if (rf == 0) return 0;
        c = (req < mn) ? mn : ((req > mx) ? mx : req);
        r = ((c + rf - 1) / rf) * rf;
        if (r > mx) r = r - rf;
        return r;
    endfunction

    task automatic run_calc(input longint req, input longint rf, input longint mn,
                            input longint mx, input longint th, input bit poke_busy);
        longint er, el;
        bit eb, ee;
        int wait_cyc;
        er = exp_rate(req, rf, mn, mx);
        el = (rf == 0) ? 0 : er / rf;
        eb = (rf != 0) && (er > th);
        ee = (rf == 0);
        @(negedge clk);
        req_rate = W'(req); ref_rate = W'(rf); min_rate = W'(mn);
        max_rate = W'(mx); vco_thresh = W'(th); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (rf != 0) check(busy, "R8 busy after start", longint'(busy), 1);
        if (poke_busy && busy) begin
            req_rate = W'(mx); min_rate = '0; max_rate = '1; vco_thresh = '0; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            req_rate = W'(req); min_rate = W'(mn); max_rate = W'(mx); vco_thresh = W'(th);
        end
        wait_cyc = 0;
        while (!valid && wait_cyc < 100) begin
            @(negedge clk);
            wait_cyc++;
        end
        check(valid, "R8 valid seen", longint'(valid), 1);
        check(rate_out == W'(er), "R1 R2 R3 rate_out", longint'(rate_out), er);
        check(mult_l == W'(el), "R4 mult_l", longint'(mult_l), el);
        check(vco_hi == eb, "R5 vco_hi", longint'(vco_hi), longint'(eb));
        check(ref_err == ee, "R7 ref_err", longint'(ref_err), longint'(ee));
        check(!busy, "R8 idle at valid", longint'(busy), 0);
        @(negedge clk);
        check(!valid, "R8 valid single cycle", longint'(valid), 0);
        check(rate_out == W'(er) && mult_l == W'(el), "R10 results held",
              longint'(rate_out), er);
        check(cur_rate == (2*W)'(el * rf), "R6 cur_rate", longint'(cur_rate), el * rf);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        longint mn, mx, rf;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check(!valid && !busy && !ref_err && !vco_hi, "R9 reset flags", longint'(valid), 0);
        check(rate_out == 0 && mult_l == 0 && cur_rate == 0, "R9 reset values",
              longint'(rate_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        ref_rate = 16'd7;
        @(negedge clk);
        check(cur_rate == 0, "R6 cur_rate with zero mult", longint'(cur_rate), 0);

        run_calc(10, 30, 50, 500, 100, 1'b0);       // R1 below window -> 60
        run_calc(9000, 30, 50, 500, 100, 1'b0);     // R1 above window -> 480
        run_calc(95, 30, 0, 100, 50, 1'b0);         // R3 overshoot -> 90
        run_calc(120, 30, 0, 1000, 120, 1'b0);      // R2 exact multiple, R5 equal thresh
        run_calc(121, 30, 0, 1000, 120, 1'b0);      // R5 above thresh -> 150
        run_calc(50, 200, 0, 100, 10, 1'b0);        // R3 ref above window -> 0
        run_calc(65535, 40000, 0, 65535, 1, 1'b0);  // R3 carry past width -> 40000
        run_calc(65535, 1, 0, 65535, 65534, 1'b0);  // R4 largest mult
        run_calc(500, 0, 0, 1000, 10, 1'b0);        // R7 zero reference
        run_calc(500, 33, 0, 1000, 10, 1'b0);       // R7 error cleared
        run_calc(300, 70, 0, 1000, 200, 1'b1);      // R8 start while busy ignored
        run_calc(0, 5, 0, 0, 0, 1'b0);              // R1 zero window

        for (int i = 0; i < 300; i++) begin
            mn = longint'($urandom % 65536);
            mx = mn + longint'($urandom % (65536 - mn));
            case ($urandom % 3)
                0: rf = 1 + longint'($urandom % 300);
                1: rf = 1 + longint'($urandom % 65535);
                default: rf = (($urandom % 16) == 0) ? 0 : 1 + longint'($urandom % 4000);
            endcase
            run_calc(longint'($urandom % 65536), rf, mn, mx,
                     longint'($urandom % 65536), (($urandom % 8) == 0));
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule